// File: doc/BRIEF.md
# Bounding-Box Rectangle Render Engine

This block draws one display object at a time into a frame buffer that sits behind a shared memory bus. An object is a rectangle given by its upper and lower row and its leftmost and rightmost column, all inclusive. It also carries a mode bit. In fill mode every pixel of the rectangle gets one colour value. In copy mode the pixels come from an image store that the engine addresses one word at a time.

Objects arrive over a valid/ready handshake. This lets a game engine stream the court walls, the paddles and the ball one after another. For each object the engine raises a bus request and waits for the grant. It then writes the rectangle pixel by pixel. Each write is held until the memory acknowledges it. When the last pixel has been accepted, the engine drops the request and pulses a completion flag. A rectangle whose bounds are inverted is finished without touching the bus.

Top module: `rre_engine`

## Requirements
- R1: After a synchronous reset, obj_ready is 1 and bus_req, wr_en and done are all 0.
- R2: wr_en is asserted only while bus_req and bus_gnt are both 1. No write is presented before the grant, however long the grant takes to arrive.
- R3: Pixels are written in raster order: columns rise from left to right within a row, then rows rise from top to bottom. Each address is row * LINE_PITCH + column, with LINE_PITCH = 320.
- R4: In fill mode (obj_is_image = 0), every write carries obj_color.
- R5: In copy mode (obj_is_image = 1), the k-th pixel of an object (counting from 0) is written with the image word read at img_addr = k. The count restarts at 0 for every new object.
- R6: While wr_en is 1 and wr_ack is 0, the next cycle still has wr_en = 1, with the same wr_addr and img_addr.
- R7: An object with a non-empty box produces exactly (right-left+1)*(bottom-top+1) acknowledged writes, all inside the box.
- R8: done is a single-cycle pulse. It appears in the cycle after the final acknowledged write, with bus_req already 0, and obj_ready returns to 1 in the following cycle.
- R9: An object with left > right or top > bottom never raises bus_req or wr_en. Its done pulse appears in the cycle after it is accepted.
- R10: obj_ready is 0 from acceptance until done. Descriptor inputs and obj_valid presented in that window are ignored and do not change the pixels being drawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_valid | input | 1 | A descriptor is offered |
| obj_ready | output | 1 | Engine is idle and takes the descriptor |
| obj_top | input | 8 | First row of the box |
| obj_bottom | input | 8 | Last row of the box (inclusive) |
| obj_left | input | 8 | First column of the box |
| obj_right | input | 8 | Last column of the box (inclusive) |
| obj_is_image | input | 1 | 1 = copy from image store, 0 = solid fill |
| obj_color | input | 16 | Fill colour |
| img_addr | output | 16 | Word address into the image store |
| img_data | input | 16 | Image word at img_addr, same cycle |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| wr_en | output | 1 | Write presented |
| wr_addr | output | 17 | Frame-buffer word address |
| wr_data | output | 16 | Pixel value |
| wr_ack | input | 1 | Write accepted this cycle |
| done | output | 1 | Object finished (one-cycle pulse) |

## Verification
The properties assume three things about the surroundings.

- Once the bus is granted, the grant stays high for as long as the request is held.
- The image store answers combinationally, in the same cycle as the address.
- An acknowledge only ever arrives while a write is presented.

The bench acts as both arbiter and memory, so it keeps to all three by construction: it raises the grant after a chosen delay and lowers it only after the request falls, it computes image words from the address with a pure function, and it drives the acknowledge only in cycles where it has seen wr_en high. Stall patterns and grant delays are varied between objects so that the hold behaviour and the no-write-before-grant rule are both exercised.

// File: rtl/rre_pkg.sv
package rre_pkg;

    parameter int unsigned COORD_W    = 8;
    parameter int unsigned PIX_W      = 16;
    parameter int unsigned LINE_PITCH = 320;
    parameter int unsigned FB_AW      = $clog2(LINE_PITCH << COORD_W);
    parameter int unsigned IMG_AW     = 2 * COORD_W;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [PIX_W-1:0]   pixel_t;
    typedef logic [FB_AW-1:0]   fb_addr_t;
    typedef logic [IMG_AW-1:0]  img_addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } rre_state_t;

    typedef struct packed {
        coord_t top;
        coord_t bottom;
        coord_t left;
        coord_t right;
        logic   is_image;
        pixel_t color;
    } obj_desc_t;

    typedef struct packed {
        coord_t row;
        coord_t col;
    } pos_t;

    function automatic fb_addr_t pix_addr(input coord_t row, input coord_t col);
        fb_addr_t r;
        fb_addr_t c;
        r = fb_addr_t'(row);
        c = fb_addr_t'(col);
        return fb_addr_t'(r * fb_addr_t'(LINE_PITCH)) + c;
    endfunction

    function automatic logic box_empty(input coord_t top, input coord_t bottom,
                                       input coord_t left, input coord_t right);
        return (left > right) || (top > bottom);
    endfunction

endpackage

// File: rtl/rre_ctrl.sv
module rre_ctrl
    import rre_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       obj_valid,
    input  logic       obj_empty,
    input  logic       bus_gnt,
    input  logic       wr_ack,
    input  logic       at_last,
    output rre_state_t state,
    output logic       accept,
    output logic       step,
    output logic       obj_ready,
    output logic       bus_req,
    output logic       wr_en,
    output logic       done
);

    rre_state_t nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (obj_valid) begin
                    nxt = obj_empty ? ST_DONE : ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    nxt = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_ack && at_last) begin
                    nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        obj_ready = (state == ST_IDLE);
        accept    = obj_ready && obj_valid;
        bus_req   = (state == ST_REQ) || (state == ST_WRITE);
        wr_en     = (state == ST_WRITE);
        step      = wr_en && wr_ack;
        done      = (state == ST_DONE);
    end

    // R2
    wr_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (bus_gnt && bus_req));

    // R2
    req_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(bus_req));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && obj_ready));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_last) |=> (done && !bus_req));

    // R9
    empty_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && obj_empty) |=> (done && !bus_req && !wr_en));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !obj_empty) |=> !obj_ready);

endmodule

// File: rtl/rre_walker.sv
module rre_walker
    import rre_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step,
    input  coord_t   start_row,
    input  coord_t   start_col,
    input  coord_t   bound_left,
    input  coord_t   bound_right,
    input  coord_t   bound_bottom,
    output pos_t     pos,
    output logic     at_last,
    output fb_addr_t fb_addr
);

    logic row_end;

    always_comb begin
        row_end = (pos.col == bound_right);
        at_last = row_end && (pos.row == bound_bottom);
        fb_addr = pix_addr(pos.row, pos.col);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (load) begin
            pos.row <= start_row;
            pos.col <= start_col;
        end else if (step) begin
            if (row_end) begin
                pos.col <= bound_left;
                pos.row <= pos.row + coord_t'(1);
            end else begin
                pos.col <= pos.col + coord_t'(1);
            end
        end
    end

    // R3
    col_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !row_end) |=> (pos.col == coord_t'($past(pos.col) + 1'b1)
                                         && $stable(pos.row)));

    // R3
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && row_end && !at_last) |=>
            (pos.col == $past(bound_left) && pos.row == coord_t'($past(pos.row) + 1'b1)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(pos));

endmodule

// File: rtl/rre_src.sv
module rre_src
    import rre_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      step,
    input  logic      is_image,
    input  pixel_t    fill_color,
    input  pixel_t    img_word,
    output img_addr_t img_index,
    output pixel_t    pix_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            img_index <= '0;
        end else if (load) begin
            img_index <= '0;
        end else if (step) begin
            img_index <= img_index + img_addr_t'(1);
        end
    end

    always_comb begin
        pix_out = is_image ? img_word : fill_color;
    end

    // R5
    img_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (img_index == '0));

    // R5
    img_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (img_index == img_addr_t'($past(img_index) + 1'b1)));

endmodule

// File: rtl/rre_engine.sv
module rre_engine
    import rre_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  obj_valid,
    output logic                  obj_ready,
    input  logic [COORD_W-1:0]    obj_top,
    input  logic [COORD_W-1:0]    obj_bottom,
    input  logic [COORD_W-1:0]    obj_left,
    input  logic [COORD_W-1:0]    obj_right,
    input  logic                  obj_is_image,
    input  logic [PIX_W-1:0]      obj_color,
    output logic [IMG_AW-1:0]     img_addr,
    input  logic [PIX_W-1:0]      img_data,
    output logic                  bus_req,
    input  logic                  bus_gnt,
    output logic                  wr_en,
    output logic [FB_AW-1:0]      wr_addr,
    output logic [PIX_W-1:0]      wr_data,
    input  logic                  wr_ack,
    output logic                  done
);

    obj_desc_t  desc_q;
    obj_desc_t  desc_in;
    rre_state_t state;
    logic       accept;
    logic       step;
    logic       in_empty;
    logic       at_last;
    pos_t       pos;

    always_comb begin
        desc_in.top      = obj_top;
        desc_in.bottom   = obj_bottom;
        desc_in.left     = obj_left;
        desc_in.right    = obj_right;
        desc_in.is_image = obj_is_image;
        desc_in.color    = obj_color;
        in_empty = box_empty(obj_top, obj_bottom, obj_left, obj_right);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
        end else if (accept) begin
            desc_q <= desc_in;
        end
    end

    rre_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .obj_valid (obj_valid),
        .obj_empty (in_empty),
        .bus_gnt   (bus_gnt),
        .wr_ack    (wr_ack),
        .at_last   (at_last),
        .state     (state),
        .accept    (accept),
        .step      (step),
        .obj_ready (obj_ready),
        .bus_req   (bus_req),
        .wr_en     (wr_en),
        .done      (done)
    );

    rre_walker u_walker (
        .clk          (clk),
        .rst          (rst),
        .load         (accept),
        .step         (step),
        .start_row    (obj_top),
        .start_col    (obj_left),
        .bound_left   (desc_q.left),
        .bound_right  (desc_q.right),
        .bound_bottom (desc_q.bottom),
        .pos          (pos),
        .at_last      (at_last),
        .fb_addr      (wr_addr)
    );

    rre_src u_src (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .step       (step),
        .is_image   (desc_q.is_image),
        .fill_color (desc_q.color),
        .img_word   (img_data),
        .img_index  (img_addr),
        .pix_out    (wr_data)
    );

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ack) |=> (wr_en && $stable(wr_addr) && $stable(img_addr)));

    // R7
    inside_box_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (pos.row >= desc_q.top && pos.row <= desc_q.bottom &&
                   pos.col >= desc_q.left && pos.col <= desc_q.right));

    // R10
    desc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!obj_ready && state != ST_DONE) |=> $stable(desc_q));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!bus_req && !wr_en && !done));

endmodule

// File: tb/rre_engine_bench.sv
`timescale 1ns/1ps
module rre_engine_bench;
    import rre_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              obj_valid;
    logic              obj_ready;
    logic [COORD_W-1:0] obj_top, obj_bottom, obj_left, obj_right;
    logic              obj_is_image;
    logic [PIX_W-1:0]  obj_color;
    logic [IMG_AW-1:0] img_addr;
    logic [PIX_W-1:0]  img_data;
    logic              bus_req, bus_gnt, wr_en, wr_ack, done;
    logic [FB_AW-1:0]  wr_addr;
    logic [PIX_W-1:0]  wr_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign img_data = PIX_W'(img_addr * 16'd7 + 16'd3);

    rre_engine u_rre_engine (
        .clk          (clk),
        .rst          (rst),
        .obj_valid    (obj_valid),
        .obj_ready    (obj_ready),
        .obj_top      (obj_top),
        .obj_bottom   (obj_bottom),
        .obj_left     (obj_left),
        .obj_right    (obj_right),
        .obj_is_image (obj_is_image),
        .obj_color    (obj_color),
        .img_addr     (img_addr),
        .img_data     (img_data),
        .bus_req      (bus_req),
        .bus_gnt      (bus_gnt),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_ack       (wr_ack),
        .done         (done)
    );

    function automatic int exp_img(input int k);
        return (k * 7 + 3) & 16'hFFFF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives one object and plays arbiter and memory. It checks every write and the completion.
    task automatic run_obj(input int t, input int b, input int l, input int r,
                           input bit img, input int color, input int gdly,
                           input int smod, input bit poke);
        int w, h, n, k, cyc, gcnt, last_ack, prev_addr, prev_img;
        bit seen_done, prev_stall, saw_req, ack;
        w = r - l + 1;
        h = b - t + 1;
        n = (w > 0 && h > 0) ? w * h : 0;
        @(negedge clk);
        chk(obj_ready == 1'b1, "R8", "ready before object", obj_ready, 1);
        obj_top = COORD_W'(t); obj_bottom = COORD_W'(b);
        obj_left = COORD_W'(l); obj_right = COORD_W'(r);
        obj_is_image = img; obj_color = PIX_W'(color); obj_valid = 1'b1;
        @(negedge clk);
        obj_valid = 1'b0;
        k = 0; cyc = 0; gcnt = 0; last_ack = -1; seen_done = 0;
        prev_stall = 0; saw_req = 0; prev_addr = 0; prev_img = 0;
        while (!seen_done && cyc < 20000) begin
            if (poke && cyc == 2) begin
                // R10: descriptor noise while busy
                obj_top = 0; obj_left = 0; obj_bottom = 9; obj_right = 9;
                obj_is_image = ~img; obj_color = 16'hDEAD; obj_valid = 1'b1;
                chk(obj_ready == 1'b0, "R10", "ready while busy", obj_ready, 0);
            end else if (poke && cyc == 3) begin
                obj_valid = 1'b0;
            end
            if (done) begin
                seen_done = 1;
                chk(k == n, "R7", "acknowledged write count", k, n);
                chk(bus_req == 1'b0, "R8", "bus_req with done", bus_req, 0);
                if (n > 0)
                    chk(cyc == last_ack + 1, "R8", "done cycle", cyc, last_ack + 1);
                else begin
                    chk(cyc == 0, "R9", "empty object done cycle", cyc, 0);
                    chk(saw_req == 0, "R9", "bus_req for empty object", saw_req, 0);
                end
                wr_ack = 1'b0;
                bus_gnt = 1'b0;
            end else begin
                if (bus_req) saw_req = 1;
                if (wr_en) begin
                    int er, ec, ea;
                    chk(bus_gnt == 1'b1, "R2", "write without grant", bus_gnt, 1);
                    er = t + k / w;
                    ec = l + k % w;
                    ea = er * LINE_PITCH + ec;
                    chk(int'(wr_addr) == ea, "R3", "raster address", wr_addr, ea);
                    if (img) begin
                        chk(int'(img_addr) == k, "R5", "image index", img_addr, k);
                        chk(int'(wr_data) == exp_img(k), "R5", "image pixel", wr_data, exp_img(k));
                    end else begin
                        chk(int'(wr_data) == color, "R4", "fill colour", wr_data, color);
                    end
                    if (prev_stall) begin
                        chk(int'(wr_addr) == prev_addr && int'(img_addr) == prev_img,
                            "R6", "address held in stall", wr_addr, prev_addr);
                    end
                    ack = !(smod > 0 && (cyc % smod) == 0);
                    wr_ack = ack;
                    prev_stall = !ack;
                    prev_addr = int'(wr_addr);
                    prev_img = int'(img_addr);
                    if (ack) begin
                        k++;
                        last_ack = cyc;
                    end
                end else begin
                    if (prev_stall)
                        chk(1'b0, "R6", "wr_en dropped in stall", 0, 1);
                    prev_stall = 0;
                    wr_ack = 1'b0;
                    if (bus_req && !bus_gnt) begin
                        if (gcnt >= gdly) bus_gnt = 1'b1;
                        else gcnt++;
                    end
                    if (!bus_req) bus_gnt = 1'b0;
                end
            end
            @(negedge clk);
            cyc++;
        end
        chk(seen_done == 1, "R8", "object completed", seen_done, 1);
        chk(done == 1'b0 && obj_ready == 1'b1, "R8", "done is one cycle, back to ready",
            {done, obj_ready}, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; obj_valid = 0; bus_gnt = 0; wr_ack = 0;
        obj_top = 0; obj_bottom = 0; obj_left = 0; obj_right = 0;
        obj_is_image = 0; obj_color = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(obj_ready == 1'b1, "R1", "obj_ready after reset", obj_ready, 1);
        chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        chk(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
    endtask

    task automatic t_solid_fill();
        // R4 R3 R7 with grant delay: R2
        run_obj(10, 12, 20, 23, 0, 16'h1234, 4, 0, 0);
    endtask

    task automatic t_image_copy_stalls();
        // R5 R6
        run_obj(3, 4, 100, 104, 1, 0, 1, 3, 0);
    endtask

    task automatic t_image_restart();
        // R5: second copy restarts image index at 0
        run_obj(50, 52, 7, 8, 1, 0, 0, 2, 0);
    endtask

    task automatic t_single_pixel();
        // R7 single pixel
        run_obj(9, 9, 9, 9, 0, 16'h00AA, 0, 0, 0);
    endtask

    task automatic t_empty_boxes();
        // R9
        run_obj(5, 6, 30, 29, 0, 16'h0F0F, 0, 0, 0);
        run_obj(40, 39, 1, 3, 1, 0, 0, 0, 0);
    endtask

    task automatic t_ignore_while_busy();
        // R10
        run_obj(100, 102, 60, 63, 0, 16'h7777, 3, 4, 1);
    endtask

    task automatic t_far_corner();
        // R3 highest address
        run_obj(254, 255, 253, 255, 1, 0, 2, 5, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_solid_fill();
        t_image_copy_stalls();
        t_image_restart();
        t_single_pixel();
        t_empty_boxes();
        t_ignore_while_busy();
        t_far_corner();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule